// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block collects the event flags of an Ethernet MAC into a 32-bit event status register, gates them with a 32-bit enable mask, and fans the result out onto thirteen separate level-sensitive interrupt lines. Event sources inside the MAC raise flags through one-cycle set pulses. Software reads the status and mask through a small register port. It acknowledges events by writing ones to the status register.

Two register writes raise events directly. A write to the management frame register flags the MII event. A write to the transmit control register with bit 0 set flags the graceful-stop event at once. Each interrupt line is registered. It is high while its status flag and its mask bit are both set. A controller reset pulse clears the status and the mask.

Top module: `evt_irq_fanout`

## Requirements
- R1: The thirteen event flags occupy status bits 31 down to 19, in this order from bit 31: heartbeat, babbling receive, babbling transmit, graceful stop, TX frame, TX buffer, RX frame, RX buffer, MII, bus error, late collision, retry limit, underrun. `ev_set_i[k]` sets status bit 19+k. Status bits 18..0 always read 0.
- R2: Interrupt lines 0 to 12 carry, in order: TX frame (bit 27), TX buffer (26), underrun (19), retry limit (20), RX frame (25), RX buffer (24), MII (23), late collision (21), heartbeat (31), graceful stop (28), bus error (22), babbling transmit (29), babbling receive (30).
- R3: A write to the status register (address 0) clears every status bit that is 1 in the written data. All other status bits keep their value.
- R4: A write to the mask register (address 1) replaces all 32 mask bits. The mask reads back exactly as written.
- R5: `irq_o[n]` is high exactly when the status flag and mask bit of line n were both set one cycle earlier. The output is registered, so it follows a status or mask change by one clock.
- R6: Any write to the management frame register (address 2) sets the MII flag (bit 23), whatever the data.
- R7: A write to the transmit control register (address 3) with data bit 0 set sets the graceful-stop flag (bit 28). With data bit 0 clear, the write changes no flag.
- R8: A `ctrl_reset_i` pulse clears status and mask to zero in the next cycle, even when set pulses or register writes arrive in the same cycle.
- R9: When a set pulse and a software clear hit the same status bit in one cycle, the bit ends up set.
- R10: `reg_rdata_o` combinationally returns the status at address 0 and the mask at address 1. It returns zero at every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset_i | input | 1 | Synchronous controller reset pulse |
| ev_set_i | input | 13 | Event set pulses; bit k sets status bit 19+k |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 13 | Registered level interrupt lines |

## Verification
Two functions can act on the same status bit in one cycle: a hardware set pulse and a software write-one-to-clear. The bench drives both onto chosen bits in a single clock, then reads the status back. The colliding bits must be set. The bits that were only cleared must be zero. The bench also lands a controller reset on top of set pulses and a management write in the same cycle, and requires status, mask and every interrupt line to read zero afterwards.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int REG_W  = 32;
  localparam int NUM_EV = 13;
  localparam int EV_LSB = REG_W - NUM_EV;

  // register addresses
  localparam int A_STATUS = 0;
  localparam int A_MASK   = 1;
  localparam int A_MGMT   = 2;
  localparam int A_TXCTL  = 3;

  // event indices relative to EV_LSB
  localparam int EV_MII = 23 - EV_LSB;
  localparam int EV_GRA = 28 - EV_LSB;

  // interrupt line -> event index (status bit minus EV_LSB)
  function automatic int irq_src(input int line);
    int bitpos;
    case (line)
      0:  bitpos = 27;
      1:  bitpos = 26;
      2:  bitpos = 19;
      3:  bitpos = 20;
      4:  bitpos = 25;
      5:  bitpos = 24;
      6:  bitpos = 23;
      7:  bitpos = 21;
      8:  bitpos = 31;
      9:  bitpos = 28;
      10: bitpos = 22;
      11: bitpos = 29;
      default: bitpos = 30;
    endcase
    return bitpos - EV_LSB;
  endfunction
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int N = evt_pkg::NUM_EV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (clear_all) status_q <= '0;
    else                status_q <= (status_q & ~clr_vec) | set_vec;
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_all) |-> ((status_q & ($past(clr_vec) & ~$past(set_vec))) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_all) |-> ((status_q & $past(set_vec)) == $past(set_vec))); // R9

  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_all) |-> ((status_q & ~($past(set_vec) | $past(clr_vec))) ==
                           ($past(status_q) & ~($past(set_vec) | $past(clr_vec))))); // R3
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int W = evt_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (clear_all) mask_q <= '0;
    else if (wr_en)     mask_q <= wdata;
  end

  AST_MASK_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(clear_all)) |-> (mask_q == $past(wdata))); // R4
endmodule

// File: rtl/evt_irq_map.sv
module evt_irq_map #(
  parameter int N = evt_pkg::NUM_EV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_status,
  input  logic [N-1:0] ev_mask,
  output logic [N-1:0] irq_q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    localparam int SRC = evt_pkg::irq_src(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= ev_status[SRC] & ev_mask[SRC];
    end
  end
endmodule

// File: rtl/evt_irq_fanout.sv
module evt_irq_fanout #(
  parameter int DATA_W = evt_pkg::REG_W,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_reset_i,
  input  logic [evt_pkg::NUM_EV-1:0] ev_set_i,
  input  logic                     reg_wr_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic [evt_pkg::NUM_EV-1:0] irq_o
);
  import evt_pkg::*;
  localparam int N   = NUM_EV;
  localparam int LSB = DATA_W - N;

  logic          wr_status, wr_mask, wr_mgmt, wr_txctl;
  logic [N-1:0]  set_vec, clr_vec, status_q;
  logic [DATA_W-1:0] mask_q;

  assign wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(A_STATUS));
  assign wr_mask   = reg_wr_i && (reg_addr_i == ADDR_W'(A_MASK));
  assign wr_mgmt   = reg_wr_i && (reg_addr_i == ADDR_W'(A_MGMT));
  assign wr_txctl  = reg_wr_i && (reg_addr_i == ADDR_W'(A_TXCTL));

  always_comb begin
    set_vec = ev_set_i;
    if (wr_mgmt)                   set_vec[EV_MII] = 1'b1;
    if (wr_txctl && reg_wdata_i[0]) set_vec[EV_GRA] = 1'b1;
    clr_vec = wr_status ? reg_wdata_i[DATA_W-1:LSB] : '0;
  end

  evt_status_reg #(.N(N)) i_status (
    .clk(clk), .rst_n(rst_n), .clear_all(ctrl_reset_i),
    .set_vec(set_vec), .clr_vec(clr_vec), .status_q(status_q));

  evt_mask_reg #(.W(DATA_W)) i_mask (
    .clk(clk), .rst_n(rst_n), .clear_all(ctrl_reset_i),
    .wr_en(wr_mask), .wdata(reg_wdata_i), .mask_q(mask_q));

  evt_irq_map #(.N(N)) i_map (
    .clk(clk), .rst_n(rst_n), .ev_status(status_q),
    .ev_mask(mask_q[DATA_W-1:LSB]), .irq_q(irq_o));

  always_comb begin
    if (reg_addr_i == ADDR_W'(A_STATUS))    reg_rdata_o = {status_q, {LSB{1'b0}}};
    else if (reg_addr_i == ADDR_W'(A_MASK)) reg_rdata_o = mask_q;
    else                                    reg_rdata_o = '0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_reset_i) |-> (status_q == '0 && mask_q == '0)); // R8

  AST_MII_ON_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_mgmt) && !$past(ctrl_reset_i)) |-> status_q[EV_MII]); // R6

  AST_GRA_ON_TXCTL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_txctl) && $past(reg_wdata_i[0]) && !$past(ctrl_reset_i)) |-> status_q[EV_GRA]); // R7

  for (genvar g = 0; g < N; g++) begin : g_chk
    localparam int SRC = irq_src(g);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> ($past(mask_q[LSB+SRC]) && $past(status_q[SRC]))); // R5
  end
endmodule

// File: tb/test_evt_irq_fanout.sv
`timescale 1ns/1ps
module test_evt_irq_fanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_reset_i = 1'b0;
  logic [12:0] ev_set_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [12:0] irq_o;

  int checks = 0;
  int errors = 0;
  int lmap [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #10 clk = ~clk; // 50 MHz

  evt_irq_fanout i_evt_irq_fanout (
    .clk(clk), .rst_n(rst_n), .ctrl_reset_i(ctrl_reset_i), .ev_set_i(ev_set_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // one write cycle, optional set pulses alongside
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [12:0] s);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; ev_set_i = s;
    step();
    reg_wr_i = 1'b0; ev_set_i = '0; reg_wdata_i = '0;
  endtask

  task automatic pulse(input logic [12:0] s);
    ev_set_i = s; step(); ev_set_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  function automatic logic [12:0] irq_exp(input logic [31:0] st, input logic [31:0] mk);
    logic [12:0] r;
    for (int n = 0; n < 13; n++) r[n] = st[lmap[n]] & mk[lmap[n]];
    return r;
  endfunction

  task automatic clean();
    wr(4'd0, 32'hFFFF_FFFF, '0);
    wr(4'd1, 32'h0, '0);
    step();
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(4'd0, d); check(d == 0, "R8 status after reset", d, 0);
    rd(4'd1, d); check(d == 0, "R8 mask after reset", d, 0);
    check(irq_o == 0, "R5 irq after reset", irq_o, 0);
  endtask

  task automatic t_each_event();
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF, '0);
    for (int k = 0; k < 13; k++) begin
      pulse(13'(1) << k);
      rd(4'd0, d);
      check(d == (32'h1 << (19 + k)), "R1 set pulse position", d, 32'h1 << (19 + k));
      step();
      check(irq_o == irq_exp(32'h1 << (19 + k), 32'hFFFF_FFFF), "R2 line mapping",
            irq_o, irq_exp(32'h1 << (19 + k), 32'hFFFF_FFFF));
      wr(4'd0, 32'h1 << (19 + k), '0);
      rd(4'd0, d); check(d == 0, "R3 clear single", d, 0);
    end
    clean();
  endtask

  task automatic t_w1c_partial();
    logic [31:0] d;
    pulse(13'h1FFF);
    wr(4'd0, 32'hA5A5_A5A5, '0);
    rd(4'd0, d);
    check(d == (32'hFFF8_0000 & ~32'hA5A5_A5A5), "R3 partial clear", d, 32'hFFF8_0000 & ~32'hA5A5_A5A5);
    wr(4'd0, 32'h0007_FFFF, '0);
    rd(4'd0, d);
    check(d == (32'hFFF8_0000 & ~32'hA5A5_A5A5), "R1 low bits no effect", d, 32'hFFF8_0000 & ~32'hA5A5_A5A5);
    clean();
  endtask

  task automatic t_mask_and_latency();
    logic [31:0] d;
    wr(4'd1, 32'h1234_5678, '0);
    rd(4'd1, d); check(d == 32'h1234_5678, "R4 mask readback", d, 32'h1234_5678);
    wr(4'd1, 32'hC3F0_0001, '0);
    rd(4'd1, d); check(d == 32'hC3F0_0001, "R4 mask replace", d, 32'hC3F0_0001);
    pulse(13'h1FFF);
    check(irq_o == 0, "R5 irq not yet", irq_o, 0);
    step();
    check(irq_o == irq_exp(32'hFFF8_0000, 32'hC3F0_0001), "R5 masked lines",
          irq_o, irq_exp(32'hFFF8_0000, 32'hC3F0_0001));
    wr(4'd1, 32'h0, '0);
    check(irq_o == irq_exp(32'hFFF8_0000, 32'hC3F0_0001), "R5 one-cycle lag on mask",
          irq_o, irq_exp(32'hFFF8_0000, 32'hC3F0_0001));
    step();
    check(irq_o == 0, "R5 mask off drops lines", irq_o, 0);
    clean();
  endtask

  task automatic t_reg_events();
    logic [31:0] d;
    wr(4'd2, 32'h0, '0);
    rd(4'd0, d); check(d == 32'h0080_0000, "R6 mgmt write sets MII", d, 32'h0080_0000);
    wr(4'd0, 32'hFFFF_FFFF, '0);
    wr(4'd3, 32'hFFFF_FFFE, '0);
    rd(4'd0, d); check(d == 0, "R7 txctl bit0 clear no event", d, 0);
    wr(4'd3, 32'h1, '0);
    rd(4'd0, d); check(d == 32'h1000_0000, "R7 txctl bit0 sets graceful stop", d, 32'h1000_0000);
    rd(4'd5, d); check(d == 0, "R10 unmapped address reads zero", d, 0);
    rd(4'd2, d); check(d == 0, "R10 mgmt address reads zero", d, 0);
    clean();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pulse(13'h1FFF);
    // clear all, set bits 19+0 and 19+7 in same cycle
    wr(4'd0, 32'hFFFF_FFFF, 13'h0081);
    rd(4'd0, d);
    check(d == 32'h0408_0000, "R9 set beats clear", d, 32'h0408_0000);
    clean();
  endtask

  task automatic t_ctrl_reset();
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF, '0);
    pulse(13'h0F0F);
    step();
    check(irq_o != 0, "R5 lines up before reset", irq_o, irq_exp(32'h0, 32'h0));
    ctrl_reset_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 4'd2; ev_set_i = 13'h1FFF;
    step();
    ctrl_reset_i = 1'b0; reg_wr_i = 1'b0; ev_set_i = '0;
    rd(4'd0, d); check(d == 0, "R8 status cleared over sets", d, 0);
    rd(4'd1, d); check(d == 0, "R8 mask cleared", d, 0);
    step();
    check(irq_o == 0, "R8 lines drop", irq_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_each_event();
    t_w1c_partial();
    t_mask_and_latency();
    t_reg_events();
    t_collision();
    t_ctrl_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule